// File: doc/BRIEF.md
# Packet-filter VM ALU execute unit

This unit executes the arithmetic and logic instructions of a 64-bit, ten-register packet-filter virtual machine. Each cycle it can accept one instruction: the 8-bit opcode, the current destination register value, the source register value and the 32-bit immediate. It returns the value to be written back to the destination register, a write strobe and an illegal-instruction flag. The register file, fetch, memory access and branching are handled elsewhere.

The same operation table serves a 32-bit class and a 64-bit class. Every 32-bit result is zero-extended into the full register. Most operations finish one cycle after they are accepted. Unsigned divide and modulo run on an iterative divider. While it works, `in_ready` is held low. The result comes out on `out_valid` when the divider is done.

Top module: `pfvm_alu`

## Requirements
- R1: Opcode bits [2:0] pick the class: 3'b100 is the 32-bit class and 3'b111 is the 64-bit class. Any other class value gives an illegal result: `out_illegal`=1, `out_write`=0 and `out_result`=0.
- R2: Opcode bit 3 picks the second operand. 1 selects `src_val`. 0 selects `imm`, which is sign-extended to 64 bits in the 64-bit class.
- R3: Opcode bits [7:4] pick the operation: 0 add, 1 sub, 2 mul, 3 div, 4 or, 5 and, 6 left shift, 7 logical right shift, 8 negate (-dst, the second operand is ignored), 9 mod, 10 xor, 11 move (copy of the second operand), 12 arithmetic right shift, 13 byte-order conversion. Add, sub, mul and negate wrap modulo the class width.
- R4: A 32-bit-class operation uses only the low 32 bits of both operands. Except for byte-order conversion, its result has bits [63:32] equal to zero.
- R5: A left shift and a logical right shift fill with zeros, and an arithmetic right shift copies the sign bit of the class width. The shift amount is the second operand masked to 5 bits in the 32-bit class and to 6 bits in the 64-bit class.
- R6: Divide and modulo are unsigned. An accepted divide or modulo with a non-zero divisor drops `in_ready` in the next cycle and keeps it low until its single result has appeared on `out_valid`. Results leave in the order instructions were accepted.
- R7: A zero divisor makes divide return 0 and modulo return the dividend (the low 32 bits, zero-extended, in the 32-bit class). Both cases answer in a single cycle.
- R8: Byte-order conversion acts on the full `dst_val` in either class. `imm` gives the width and must be 16, 32 or 64. With bit 3 = 0 the low `imm` bits are kept, zero-extended. With bit 3 = 1 the order of the bytes within that width is reversed, zero-extended. Any other width is illegal.
- R9: Operation values 14 and 15 are illegal: `out_illegal`=1, `out_write`=0, `out_result`=0.
- R10: Every accepted instruction other than a divide or modulo with a non-zero divisor raises `out_valid` for one cycle, in the cycle after acceptance, with `out_write` = not `out_illegal`.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | Unit can accept an instruction this cycle |
| opcode | input | 8 | Instruction opcode |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field |
| out_valid | output | 1 | Result strobe, one cycle per accepted instruction |
| out_write | output | 1 | Destination should be written with `out_result` |
| out_illegal | output | 1 | Instruction was not executable |
| out_result | output | 64 | Value for the destination register |

## Verification
Directed vectors with dirty upper halves set the two classes apart. So does an immediate whose top bit is set, which also separates the register source from the sign-extended immediate source. Shift counts above the class width show whether the amount is masked. A negative dividend under both right shifts separates zero fill from sign fill. Divide and modulo are run with full-width, 32-bit and zero divisors, which shows whether the multi-cycle path, the stall and the single-cycle zero-divisor path are told apart. A long pseudo-random stream of mixed classes and operations, with byte-order conversions at all three widths, then runs back to back through the scoreboard, so stalls and result ordering are covered too.

// File: rtl/pfvm_pkg.sv
package pfvm_pkg;
  localparam int XLEN = 64;
  localparam int HLEN = XLEN / 2;
  localparam int IMMW = 32;

  localparam logic [2:0] CLS_A32 = 3'b100;
  localparam logic [2:0] CLS_A64 = 3'b111;

  localparam logic [3:0] F_ADD  = 4'h0;
  localparam logic [3:0] F_SUB  = 4'h1;
  localparam logic [3:0] F_MUL  = 4'h2;
  localparam logic [3:0] F_DIV  = 4'h3;
  localparam logic [3:0] F_OR   = 4'h4;
  localparam logic [3:0] F_AND  = 4'h5;
  localparam logic [3:0] F_SHL  = 4'h6;
  localparam logic [3:0] F_SHR  = 4'h7;
  localparam logic [3:0] F_NEG  = 4'h8;
  localparam logic [3:0] F_MOD  = 4'h9;
  localparam logic [3:0] F_XOR  = 4'hA;
  localparam logic [3:0] F_MOV  = 4'hB;
  localparam logic [3:0] F_SAR  = 4'hC;
  localparam logic [3:0] F_BORD = 4'hD;

  typedef enum logic [1:0] {EW_BAD, EW_16, EW_32, EW_64} bord_w_e;

  function automatic logic [XLEN-1:0] zext_half(input logic [XLEN-1:0] v);
    return {{HLEN{1'b0}}, v[HLEN-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
    return {{(XLEN-IMMW){v[IMMW-1]}}, v};
  endfunction

  function automatic logic [HLEN-1:0] sar_half(input logic [HLEN-1:0] v, input logic [4:0] s);
    return HLEN'($signed(v) >>> s);
  endfunction

  function automatic bord_w_e bord_width(input logic [IMMW-1:0] v);
    case (v)
      32'd16:  return EW_16;
      32'd32:  return EW_32;
      32'd64:  return EW_64;
      default: return EW_BAD;
    endcase
  endfunction

  function automatic logic [6:0] bord_bits(input bord_w_e w);
    case (w)
      EW_16:   return 7'd16;
      EW_32:   return 7'd32;
      default: return 7'd64;
    endcase
  endfunction

  // keep the low w bits, or reverse the byte order inside those w bits
  function automatic logic [XLEN-1:0] bord_conv(input logic [XLEN-1:0] v,
                                                input bord_w_e w, input logic swap);
    logic [XLEN-1:0] rev;
    logic [6:0]      drop;
    rev  = {<<8{v}};
    drop = 7'(XLEN) - bord_bits(w);
    if (swap) return rev >> drop;
    return (v << drop) >> drop;
  endfunction
endpackage

// File: rtl/pfvm_alu_exec.sv
module pfvm_alu_exec
  import pfvm_pkg::*;
(
  input  logic [7:0]      opcode,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] result,
  output logic            illegal,
  output logic            divmod,
  output logic            div_zero,
  output logic            half,
  output logic            zext_res,
  output logic [XLEN-1:0] opa,
  output logic [XLEN-1:0] opb
);
  logic [3:0]      func;
  logic            wide;
  logic            cls_ok;
  logic [5:0]      shamt;
  logic [XLEN-1:0] raw;
  bord_w_e         bw;

  assign func   = opcode[7:4];
  assign wide   = (opcode[2:0] == CLS_A64);
  assign cls_ok = wide || (opcode[2:0] == CLS_A32);
  assign half   = !wide;
  assign bw     = bord_width(imm);

  assign opa = wide ? dst_val : zext_half(dst_val);
  always_comb begin
    if (opcode[3]) opb = wide ? src_val : zext_half(src_val);
    else           opb = wide ? sext_imm(imm) : {{(XLEN-IMMW){1'b0}}, imm};
  end

  assign shamt    = wide ? opb[5:0] : {1'b0, opb[4:0]};
  assign divmod   = (func == F_DIV) || (func == F_MOD);
  assign div_zero = (opb == '0);

  always_comb begin
    case (func)
      F_ADD:  raw = opa + opb;
      F_SUB:  raw = opa - opb;
      F_MUL:  raw = opa * opb;
      F_DIV:  raw = '0;
      F_OR:   raw = opa | opb;
      F_AND:  raw = opa & opb;
      F_SHL:  raw = opa << shamt;
      F_SHR:  raw = opa >> shamt;
      F_NEG:  raw = '0 - opa;
      F_MOD:  raw = opa;
      F_XOR:  raw = opa ^ opb;
      F_MOV:  raw = opb;
      F_SAR:  raw = wide ? XLEN'($signed(opa) >>> shamt)
                         : {{HLEN{1'b0}}, sar_half(opa[HLEN-1:0], shamt[4:0])};
      F_BORD: raw = bord_conv(dst_val, bw, opcode[3]);
      default: raw = '0;
    endcase
  end

  assign illegal  = !cls_ok || (func > F_BORD) || ((func == F_BORD) && (bw == EW_BAD));
  assign zext_res = half && (func != F_BORD);
  assign result   = zext_res ? zext_half(raw) : raw;
endmodule

// File: rtl/pfvm_divider.sv
module pfvm_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         half,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int HW = W / 2;
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  q_r;
  logic [W-1:0]  r_r;
  logic [W-1:0]  d_r;
  logic [W:0]    trial;
  logic          fits;

  // one restoring step per cycle
  assign trial = {r_r, q_r[W-1]};
  assign fits  = trial >= {1'b0, d_r};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
      q_r  <= '0;
      r_r  <= '0;
      d_r  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_r <= half ? {dividend[HW-1:0], {HW{1'b0}}} : dividend;
        r_r <= '0;
        d_r <= divisor;
        cnt <= half ? CW'(HW) : CW'(W);
      end else if (cnt != '0) begin
        r_r <= fits ? W'(trial - {1'b0, d_r}) : W'(trial);
        q_r <= {q_r[W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end

  assign quotient  = q_r;
  assign remainder = r_r;
endmodule

// File: rtl/pfvm_alu.sv
module pfvm_alu
  import pfvm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  opcode,
  input  logic [63:0] dst_val,
  input  logic [63:0] src_val,
  input  logic [31:0] imm,
  output logic        out_valid,
  output logic        out_write,
  output logic        out_illegal,
  output logic [63:0] out_result
);
  logic [XLEN-1:0] x_result, x_opa, x_opb;
  logic            x_illegal, x_divmod, x_div_zero, x_half, x_zext;
  logic            accept, div_start, div_done;
  logic            pend_busy, pend_mod, pend_half;
  logic            res32_q;
  logic [XLEN-1:0] div_q, div_r, div_pick;

  pfvm_alu_exec u_exec (
    .opcode   (opcode),
    .dst_val  (dst_val),
    .src_val  (src_val),
    .imm      (imm),
    .result   (x_result),
    .illegal  (x_illegal),
    .divmod   (x_divmod),
    .div_zero (x_div_zero),
    .half     (x_half),
    .zext_res (x_zext),
    .opa      (x_opa),
    .opb      (x_opb)
  );

  assign in_ready  = !pend_busy;
  assign accept    = in_valid && in_ready;
  assign div_start = accept && x_divmod && !x_div_zero && !x_illegal;

  pfvm_divider #(.W(XLEN)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_start),
    .half      (x_half),
    .dividend  (x_opa),
    .divisor   (x_opb),
    .done      (div_done),
    .quotient  (div_q),
    .remainder (div_r)
  );

  assign div_pick = pend_mod ? div_r : div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_busy   <= 1'b0;
      pend_mod    <= 1'b0;
      pend_half   <= 1'b0;
      out_valid   <= 1'b0;
      out_write   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
      res32_q     <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (div_start) begin
        pend_busy <= 1'b1;
        pend_mod  <= (opcode[7:4] == F_MOD);
        pend_half <= x_half;
      end else if (accept) begin
        out_valid   <= 1'b1;
        out_write   <= !x_illegal;
        out_illegal <= x_illegal;
        out_result  <= x_illegal ? '0 : x_result;
        res32_q     <= x_zext && !x_illegal;
      end else if (div_done) begin
        pend_busy   <= 1'b0;
        out_valid   <= 1'b1;
        out_write   <= 1'b1;
        out_illegal <= 1'b0;
        out_result  <= pend_half ? zext_half(div_pick) : div_pick;
        res32_q     <= pend_half;
      end
    end
  end
endmodule

// File: rtl/pfvm_alu_chk.sv
module pfvm_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  opcode,
  input logic        out_valid,
  input logic        out_write,
  input logic        out_illegal,
  input logic [63:0] out_result,
  input logic        res32_q,
  input logic        div_done
);
  logic acc, acc_dm;
  assign acc    = in_valid && in_ready;
  assign acc_dm = acc && (opcode[7:4] == 4'h3 || opcode[7:4] == 4'h9);

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_write && out_result == 64'd0); // R9
  AST_STROBE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_write == !out_illegal); // R10
  AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && res32_q |-> out_result[63:32] == 32'd0); // R4
  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !acc_dm |=> out_valid); // R10
  AST_DIV_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_dm |=> out_valid || !in_ready); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(acc) || $past(div_done)); // R6
endmodule

bind pfvm_alu pfvm_alu_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .opcode      (opcode),
  .out_valid   (out_valid),
  .out_write   (out_write),
  .out_illegal (out_illegal),
  .out_result  (out_result),
  .res32_q     (res32_q),
  .div_done    (div_done)
);

// File: tb/tb_pfvm_alu.sv
module tb_pfvm_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  opcode = '0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [31:0] imm = '0;
  logic        out_valid, out_write, out_illegal;
  logic [63:0] out_result;

  int nchk = 0;
  int nfail = 0;
  logic [63:0] exp_q[$];
  logic        ill_q[$];
  string       tag_q[$];
  logic [63:0] seed = 64'h0123_4567_89AB_CDEF;

  always #5 clk = ~clk;

  pfvm_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opcode(opcode), .dst_val(dst_val), .src_val(src_val), .imm(imm),
    .out_valid(out_valid), .out_write(out_write), .out_illegal(out_illegal),
    .out_result(out_result)
  );

  // reference model written from the requirements: {illegal, result}
  function automatic logic [64:0] model(input logic [7:0] op, input logic [63:0] d,
                                        input logic [63:0] s, input logic [31:0] im);
    logic [63:0] b, r;
    logic [31:0] a32, b32, r32;
    logic [3:0]  f;
    int          nb;
    f = op[7:4];
    b = op[3] ? s : {{32{im[31]}}, im};
    if (!(op[2:0] == 3'd4 || op[2:0] == 3'd7) || f >= 4'hE) return {1'b1, 64'd0};
    if (f == 4'hD) begin
      nb = (im == 16) ? 2 : (im == 32) ? 4 : (im == 64) ? 8 : 0;
      if (nb == 0) return {1'b1, 64'd0};
      r = '0;
      for (int i = 0; i < nb; i++)
        r[8*i +: 8] = op[3] ? d[8*(nb-1-i) +: 8] : d[8*i +: 8];
      return {1'b0, r};
    end
    if (op[2:0] == 3'd7) begin
      case (f)
        4'h0: r = d + b;
        4'h1: r = d - b;
        4'h2: r = d * b;
        4'h3: r = (b == 0) ? 64'd0 : d / b;
        4'h4: r = d | b;
        4'h5: r = d & b;
        4'h6: r = d << b[5:0];
        4'h7: r = d >> b[5:0];
        4'h8: r = -d;
        4'h9: r = (b == 0) ? d : d % b;
        4'hA: r = d ^ b;
        4'hB: r = b;
        default: r = 64'($signed(d) >>> b[5:0]);
      endcase
      return {1'b0, r};
    end
    a32 = d[31:0];
    b32 = b[31:0];
    case (f)
      4'h0: r32 = a32 + b32;
      4'h1: r32 = a32 - b32;
      4'h2: r32 = a32 * b32;
      4'h3: r32 = (b32 == 0) ? 32'd0 : a32 / b32;
      4'h4: r32 = a32 | b32;
      4'h5: r32 = a32 & b32;
      4'h6: r32 = a32 << b32[4:0];
      4'h7: r32 = a32 >> b32[4:0];
      4'h8: r32 = -a32;
      4'h9: r32 = (b32 == 0) ? a32 : a32 % b32;
      4'hA: r32 = a32 ^ b32;
      4'hB: r32 = b32;
      default: r32 = 32'($signed(a32) >>> b32[4:0]);
    endcase
    return {1'b0, 32'd0, r32};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: queue the expectation, then hand the instruction over
  task automatic issue(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                       input logic [31:0] im, input string tag);
    logic [64:0] e;
    e = model(op, d, s, im);
    exp_q.push_back(e[63:0]);
    ill_q.push_back(e[64]);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
    opcode = op; dst_val = d; src_val = s; imm = im;
    in_valid = 1'b1;
  endtask

  // monitor: compare every result with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected result", out_result, 64'd0);
      end else begin
        logic [63:0] e;
        logic        il;
        string       t;
        e = exp_q.pop_front();
        il = ill_q.pop_front();
        t = tag_q.pop_front();
        check(out_result == e && out_illegal == il && out_write == !il, t,
              {out_illegal, out_write, out_result[61:0]}, {il, !il, e[61:0]});
        if (out_result != e) $display("  %s full result %h vs %h", t, out_result, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  function automatic logic [63:0] rnd();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11 during reset",
          {62'd0, out_valid, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11 after reset",
          {62'd0, out_valid, in_ready}, 64'd1);

    issue(8'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'd0, "R3 add64 wrap");
    issue(8'h04, 64'h1234_5678_FFFF_FFFF, 64'd0, 32'd1, "R4 add32 wrap zext");
    issue(8'h17, 64'd5, 64'd99, 32'hFFFF_FFFF, "R2 sub64 imm sext");
    issue(8'h14, 64'hAAAA_0000_0000_0005, 64'd0, 32'hFFFF_FFFF, "R4 sub32 imm");
    issue(8'hB7, 64'd0, 64'd7, 32'h8000_0000, "R2 mov64 imm sext");
    issue(8'hB4, 64'd0, 64'd7, 32'h8000_0000, "R4 mov32 imm");
    issue(8'hBF, 64'd0, 64'hDEAD_BEEF_0BAD_F00D, 32'h5, "R2 mov64 reg");
    issue(8'h2F, 64'h1_0000_0003, 64'h2_0000_0005, 32'd0, "R3 mul64");
    issue(8'h2C, 64'h1_0000_0003, 64'h2_0000_0005, 32'd0, "R4 mul32");
    issue(8'h4F, 64'hF0F0_0000_0000_0001, 64'h0F00_0000_0000_0010, 32'd0, "R3 or");
    issue(8'h57, 64'hFFFF_0000_FFFF_0000, 64'd0, 32'hFF00_FF00, "R3 and imm");
    issue(8'hAF, 64'h5555_5555_5555_5555, 64'hFFFF_FFFF_0000_0000, 32'd0, "R3 xor");
    issue(8'h8F, 64'd1, 64'h1234, 32'h77, "R3 neg ignores src");
    issue(8'h84, 64'hFFFF_FFFF_0000_0001, 64'h1234, 32'h77, "R4 neg32");
    issue(8'h6F, 64'h8000_0000_0000_0001, 64'd65, 32'd0, "R5 lsh64 masked");
    issue(8'h6C, 64'h0000_0001_8000_0001, 64'd33, 32'd0, "R5 lsh32 masked");
    issue(8'h7F, 64'h8000_0000_0000_0000, 64'd4, 32'd0, "R5 rsh64 zero fill");
    issue(8'hCF, 64'h8000_0000_0000_0000, 64'd4, 32'd0, "R5 arsh64 sign fill");
    issue(8'hCC, 64'h0000_0000_8000_0000, 64'd36, 32'd0, "R5 arsh32 sign fill");
    issue(8'h74, 64'h0000_0000_8000_0000, 64'd0, 32'd36, "R5 rsh32 imm masked");

    issue(8'h3F, 64'hFFFF_FFFF_FFFF_FFFF, 64'd7, 32'd0, "R6 div64");
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R6 stall after div", {63'd0, in_ready}, 64'd0);
    issue(8'h9F, 64'hFFFF_FFFF_FFFF_FFFF, 64'd10, 32'd0, "R6 mod64");
    issue(8'h3C, 64'hFFFF_FFFF_0000_0064, 64'hABCD_0000_0000_0007, 32'd0, "R6 div32");
    issue(8'h94, 64'hFFFF_FFFF_0000_0064, 64'd0, 32'd7, "R6 mod32 imm");
    issue(8'h37, 64'd1234, 64'd0, 32'd0, "R7 div by zero");
    issue(8'h9F, 64'hCAFE_0000_1234_5678, 64'd0, 32'd0, "R7 mod64 by zero");
    issue(8'h9C, 64'hCAFE_0000_1234_5678, 64'h5_0000_0000, 32'd0, "R7 mod32 by zero");

    issue(8'hD4, 64'h1122_3344_5566_7788, 64'd0, 32'd16, "R8 native 16");
    issue(8'hDC, 64'h1122_3344_5566_7788, 64'd0, 32'd16, "R8 swap 16");
    issue(8'hDC, 64'h1122_3344_5566_7788, 64'd0, 32'd32, "R8 swap 32");
    issue(8'hDC, 64'h1122_3344_5566_7788, 64'd0, 32'd64, "R8 swap 64 in 32 class");
    issue(8'hD7, 64'h1122_3344_5566_7788, 64'd0, 32'd64, "R8 native 64");
    issue(8'hD4, 64'h1122_3344_5566_7788, 64'd0, 32'd8, "R8 bad width");
    issue(8'hE4, 64'd1, 64'd2, 32'd3, "R9 op 14");
    issue(8'hFF, 64'd1, 64'd2, 32'd3, "R9 op 15");
    issue(8'h05, 64'd1, 64'd2, 32'd3, "R1 bad class 5");
    issue(8'h0B, 64'd1, 64'd2, 32'd3, "R1 bad class 3");

    issue(8'hA7, 64'h1, 64'd0, 32'h10, "R10 xor timing");
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R10 one-cycle strobe", {63'd0, out_valid}, 64'd1);

    for (int n = 0; n < 300; n++) begin
      logic [63:0] r0, r1, r2;
      logic [7:0]  op;
      logic [31:0] im;
      r0 = rnd(); r1 = rnd(); r2 = rnd();
      op = {4'(r0[3:0] % 14), r0[4], (r0[7:5] == 3'd0) ? 3'd5 : (r0[8] ? 3'd7 : 3'd4)};
      im = r0[9] ? r0[63:32] : {28'd0, r0[13:10]};
      if (op[7:4] == 4'hD)
        im = (r0[15:14] == 2'd0) ? 32'd16 : (r0[15:14] == 2'd1) ? 32'd32 : 32'd64;
      if ((op[7:4] == 4'h3 || op[7:4] == 4'h9) && r0[16]) r2 = r2 >> r0[21:16];
      issue(op, r1, r2, im, "R3 random mix");
    end

    @(negedge clk);
    in_valid = 1'b0;
    while (exp_q.size() != 0 || !in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule